// File: doc/BRIEF.md
# Quadrature Position and Index Counter

This block turns the two phase signals and the once-per-turn index signal of a rotary encoder into a direction flag, a position count and a revolution count. The position runs between zero and a programmable maximum and wraps in both directions. The revolution count steps once on each active index edge. The block takes its inputs from the pins through a two-flop synchroniser. A shared programmable glitch filter then settles each input before any decoding takes place.

Configuration decides four things:
- whether the pins carry quadrature phases or a count clock with a direction level;
- whether only phase A edges are counted (2X) or the edges of both phases (4X);
- whether the decoded direction is complemented;
- which edge of the index input is the active one.

Three position comparators and one revolution comparator each give a single-cycle pulse when their counter is updated to a value equal to theirs. Separate pulses flag a counted step, a direction change, an index event and a phase error. Software uses a small write-only port to load the configuration, the maximum, the filter length and the compare values, and to issue one-shot commands.

Top module: `qenc_counter`

## Requirements
- R1: After reset the position, the revolution count and the direction output are zero, and no event pulse is active.
- R2: In quadrature mode, config bit 2 set (4X) counts every edge of either phase. Config bit 2 clear (2X) counts only edges of phase A. Each counted edge raises `step_evt_o` for one cycle.
- R3: A forward step from the maximum (address 2) gives 0, and a reverse step from 0 gives the maximum. Every other step moves the position by one.
- R4: In quadrature mode, phase A leading phase B is forward (`dir_o` = 0) and the opposite order is reverse (`dir_o` = 1). Config bit 0 complements the direction. A counted step whose direction differs from `dir_o` raises `dir_evt_o` for one cycle.
- R5: The active index edge is rising, or falling when config bit 3 is set. On an active edge the block pulses `idx_evt_o` and adds one to the revolution count, or subtracts one when `dir_o` is 1. The inactive edge has no effect.
- R6: In quadrature mode, if both phases change in the same filtered sample, `err_evt_o` pulses and the position is not changed.
- R7: Position compare channel k (address 4+k) pulses `pos_hit_o[k]` in the cycle the position is updated to a value equal to the channel's value.
- R8: The revolution compare register (address 7) pulses `rev_hit_o` in the cycle the revolution count is updated to a value equal to it.
- R9: A write to address 1 issues commands for that cycle only. Bit 0 clears the position. Bit 3 clears the revolution count. Bit 1 arms a clear of the position on the next active index edge, and that edge consumes the arm.
- R10: With config bit 1 set, each rising edge of phase A is one step, and the phase B level gives the direction (0 forward, 1 reverse).
- R11: An input level is taken only after it differs from the accepted level for len+1 consecutive synchronised samples, where len is the value at address 3. A pin change therefore shows on the counters and pulses len+4 clock edges after it is driven, and a shorter pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A, or count clock in clock/direction mode |
| enc_b | input | 1 | Phase B, or direction level |
| enc_idx | input | 1 | Index input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 config, 1 command, 2 maximum, 3 filter length, 4..6 position compares, 7 revolution compare |
| wr_data | input | CNT_W | Write data |
| dir_o | output | 1 | Current direction, 1 = reverse |
| pos_o | output | CNT_W | Position count |
| rev_o | output | REV_W | Revolution count |
| pos_hit_o | output | NCMP | Position compare pulses |
| rev_hit_o | output | 1 | Revolution compare pulse |
| idx_evt_o | output | 1 | Index event pulse |
| dir_evt_o | output | 1 | Direction change pulse |
| err_evt_o | output | 1 | Phase error pulse |
| step_evt_o | output | 1 | Counted step pulse |

## Verification
A pin change reaches the outputs len+4 clock edges after it is driven. Two of those edges are in the synchroniser, len in the filter wait, one is the filter acceptance and one is the counter update. A register write affects decoding from the following cycle. A command acts on the very edge that carries the write, and every compare pulse lines up with the counter value that caused it. The bench keeps a per-cycle reference model that follows this timing and compares every output on each falling edge. Targeted checks sample the position exactly one cycle before and on the cycle it is due.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic idx_inv;   // bit 3: falling index edge is active
    logic four_x;    // bit 2: count both phases
    logic clk_dir;   // bit 1: clock/direction inputs
    logic dir_inv;   // bit 0: complement direction
  } cfg_t;

  localparam int A_CFG  = 0;
  localparam int A_CMD  = 1;
  localparam int A_MAX  = 2;
  localparam int A_FLT  = 3;
  localparam int A_CMP0 = 4;

  localparam int CMD_CLR_POS = 0;
  localparam int CMD_ARM_IDX = 1;
  localparam int CMD_CLR_REV = 3;

endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int FLT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLT_W-1:0] len_i,
  input  logic             din,
  output logic             dout
);
  logic             s1_q, s2_q;
  logic [FLT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      dout  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      if (s2_q == dout) begin
        cnt_q <= '0;
      end else if (cnt_q >= len_i) begin
        dout  <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // a new level is taken only once the wait has been served
  AST_FILT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(cnt_q) >= $past(len_i))); // R11

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_i,
  input  logic a_i,
  input  logic b_i,
  input  logic x_i,
  output logic step_o,
  output logic back_o,
  output logic err_o,
  output logic idx_o
);
  logic a_q, b_q, x_q;
  logic a_chg, b_chg, back_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      x_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      x_q <= x_i;
    end
  end

  always_comb begin
    a_chg = a_i ^ a_q;
    b_chg = b_i ^ b_q;
    if (cfg_i.clk_dir) begin
      step_o   = a_i & ~a_q;
      back_raw = b_i;
      err_o    = 1'b0;
    end else begin
      err_o    = a_chg & b_chg;
      step_o   = cfg_i.four_x ? (a_chg ^ b_chg) : (a_chg & ~b_chg);
      // after an A edge, equal levels mean B leads; after a B edge, unequal
      back_raw = a_chg ? (a_i ~^ b_i) : (a_i ^ b_i);
    end
    back_o = back_raw ^ cfg_i.dir_inv;
    idx_o  = cfg_i.idx_inv ? (~x_i & x_q) : (x_i & ~x_q);
  end

endmodule

// File: rtl/qenc_track.sv
module qenc_track #(
  parameter int CNT_W = 16,
  parameter int REV_W = 12,
  parameter int NCMP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             back_i,
  input  logic             err_i,
  input  logic             idx_i,
  input  logic             clr_pos_i,
  input  logic             arm_idx_i,
  input  logic             clr_rev_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic [CNT_W-1:0] cmp_i [NCMP],
  input  logic [REV_W-1:0] rev_cmp_i,
  output logic             dir_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [REV_W-1:0] rev_o,
  output logic [NCMP-1:0]  hit_o,
  output logic             rev_hit_o,
  output logic             idx_evt_o,
  output logic             dir_evt_o,
  output logic             err_evt_o,
  output logic             step_evt_o
);

  function automatic logic [CNT_W-1:0] pos_advance(
      input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] m, input logic back);
    if (!back) return (p == m) ? '0 : p + 1'b1;
    else       return (p == '0) ? m : p - 1'b1;
  endfunction

  function automatic logic [REV_W-1:0] rev_advance(
      input logic [REV_W-1:0] r, input logic back);
    return back ? r - 1'b1 : r + 1'b1;
  endfunction

  logic             armed_q;
  logic             idx_clear;
  logic             pos_upd, rev_upd;
  logic [CNT_W-1:0] pos_n;
  logic [REV_W-1:0] rev_n;

  assign idx_clear = idx_i & armed_q;

  always_comb begin
    pos_upd = 1'b1;
    if (clr_pos_i || idx_clear) pos_n = '0;
    else if (step_i)            pos_n = pos_advance(pos_o, max_i, back_i);
    else begin
      pos_n   = pos_o;
      pos_upd = 1'b0;
    end
    rev_upd = 1'b1;
    if (clr_rev_i)  rev_n = '0;
    else if (idx_i) rev_n = rev_advance(rev_o, dir_o);
    else begin
      rev_n   = rev_o;
      rev_upd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o      <= 1'b0;
      pos_o      <= '0;
      rev_o      <= '0;
      armed_q    <= 1'b0;
      rev_hit_o  <= 1'b0;
      idx_evt_o  <= 1'b0;
      dir_evt_o  <= 1'b0;
      err_evt_o  <= 1'b0;
      step_evt_o <= 1'b0;
    end else begin
      if (step_i) dir_o <= back_i;
      dir_evt_o  <= step_i & (back_i != dir_o);
      err_evt_o  <= err_i;
      step_evt_o <= step_i;
      idx_evt_o  <= idx_i;
      armed_q    <= arm_idx_i | (armed_q & ~idx_i);
      pos_o      <= pos_n;
      rev_o      <= rev_n;
      rev_hit_o  <= rev_upd && (rev_n == rev_cmp_i);
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_hit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_o[k] <= 1'b0;
      else        hit_o[k] <= pos_upd && (pos_n == cmp_i[k]);
    end
    AST_HIT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[k] |-> (pos_o == $past(cmp_i[k]))); // R7
  end

  AST_WRAP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !back_i && pos_o == max_i && !clr_pos_i && !idx_clear)
      |=> (pos_o == '0)); // R3
  AST_WRAP_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && back_i && pos_o == '0 && !clr_pos_i && !idx_clear)
      |=> (pos_o == $past(max_i))); // R3
  AST_DIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_evt_o |-> (dir_o != $past(dir_o))); // R4
  AST_IDX_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idx_i) && !$past(clr_rev_i)) |-> (rev_o != $past(rev_o))); // R5
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_i) && !$past(clr_pos_i) && !$past(idx_clear))
      |-> (pos_o == $past(pos_o))); // R6
  AST_REV_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rev_hit_o |-> (rev_o == $past(rev_cmp_i))); // R8
  AST_CLEAR_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_pos_i) |-> (pos_o == '0)); // R9

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REV_W  = 12,
  parameter int FLT_W  = 8,
  parameter int NCMP   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              dir_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic [REV_W-1:0]  rev_o,
  output logic [NCMP-1:0]   pos_hit_o,
  output logic              rev_hit_o,
  output logic              idx_evt_o,
  output logic              dir_evt_o,
  output logic              err_evt_o,
  output logic              step_evt_o
);
  localparam int A_RCMP = A_CMP0 + NCMP;
  localparam int NIN    = 3;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] max_q;
  logic [FLT_W-1:0] flt_len_q;
  logic [CNT_W-1:0] cmp_q [NCMP];
  logic [REV_W-1:0] rev_cmp_q;

  logic [NIN-1:0] raw, filt;
  logic           cmd_hit;
  logic           clr_pos, arm_idx, clr_rev;
  logic           step, back, err, idx;

  assign raw     = {enc_idx, enc_b, enc_a};
  assign cmd_hit = wr_en && (wr_addr == ADDR_W'(A_CMD));
  assign clr_pos = cmd_hit & wr_data[CMD_CLR_POS];
  assign arm_idx = cmd_hit & wr_data[CMD_ARM_IDX];
  assign clr_rev = cmd_hit & wr_data[CMD_CLR_REV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      max_q     <= '0;
      flt_len_q <= '0;
      rev_cmp_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG))  cfg_q     <= cfg_t'(wr_data[3:0]);
      if (wr_addr == ADDR_W'(A_MAX))  max_q     <= wr_data;
      if (wr_addr == ADDR_W'(A_FLT))  flt_len_q <= wr_data[FLT_W-1:0];
      if (wr_addr == ADDR_W'(A_RCMP)) rev_cmp_q <= wr_data[REV_W-1:0];
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[k] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_CMP0 + k)) cmp_q[k] <= wr_data;
    end
  end

  for (genvar g = 0; g < NIN; g++) begin : g_flt
    qenc_filter #(.FLT_W(FLT_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .len_i (flt_len_q),
      .din   (raw[g]),
      .dout  (filt[g])
    );
  end

  qenc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg_q),
    .a_i    (filt[0]),
    .b_i    (filt[1]),
    .x_i    (filt[2]),
    .step_o (step),
    .back_o (back),
    .err_o  (err),
    .idx_o  (idx)
  );

  qenc_track #(.CNT_W(CNT_W), .REV_W(REV_W), .NCMP(NCMP)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .back_i     (back),
    .err_i      (err),
    .idx_i      (idx),
    .clr_pos_i  (clr_pos),
    .arm_idx_i  (arm_idx),
    .clr_rev_i  (clr_rev),
    .max_i      (max_q),
    .cmp_i      (cmp_q),
    .rev_cmp_i  (rev_cmp_q),
    .dir_o      (dir_o),
    .pos_o      (pos_o),
    .rev_o      (rev_o),
    .hit_o      (pos_hit_o),
    .rev_hit_o  (rev_hit_o),
    .idx_evt_o  (idx_evt_o),
    .dir_evt_o  (dir_evt_o),
    .err_evt_o  (err_evt_o),
    .step_evt_o (step_evt_o)
  );

  // the step pulse and the error pulse come from exclusive decodes
  AST_ERR_NOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_o |-> !step_evt_o); // R6

endmodule

// File: tb/qenc_counter_test.sv
module qenc_counter_test;
  localparam int HOLD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        dir_o;
  logic [15:0] pos_o;
  logic [11:0] rev_o;
  logic [2:0]  pos_hit_o;
  logic        rev_hit_o, idx_evt_o, dir_evt_o, err_evt_o, step_evt_o;

  always #2.5 clk = ~clk;

  qenc_counter uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dir_o(dir_o), .pos_o(pos_o), .rev_o(rev_o), .pos_hit_o(pos_hit_o),
    .rev_hit_o(rev_hit_o), .idx_evt_o(idx_evt_o), .dir_evt_o(dir_evt_o),
    .err_evt_o(err_evt_o), .step_evt_o(step_evt_o)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1[3], m_s2[3], m_f[3], m_cnt[3], m_p[3];
  int m_len, m_max, m_cmp[3], m_rcmp;
  bit m_dinv, m_cd, m_4x, m_iinv;
  int m_pos, m_rev;
  bit m_dir, m_arm;
  bit m_hit[3];
  bit m_rhit, m_ievt, m_devt, m_eevt, m_sevt;
  int in_v[3];
  bit ach, bch, stp, rv, er, ih, pupd, rupd, clrp, arm, clrr;
  int np, nr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_cnt[i] = 0; m_p[i] = 0;
        m_cmp[i] = 0; m_hit[i] = 0;
      end
      m_len = 0; m_max = 0; m_rcmp = 0;
      m_dinv = 0; m_cd = 0; m_4x = 0; m_iinv = 0;
      m_pos = 0; m_rev = 0; m_dir = 0; m_arm = 0;
      m_rhit = 0; m_ievt = 0; m_devt = 0; m_eevt = 0; m_sevt = 0;
    end else begin
      in_v[0] = int'(enc_a); in_v[1] = int'(enc_b); in_v[2] = int'(enc_idx);
      ach = (m_f[0] != m_p[0]);
      bch = (m_f[1] != m_p[1]);
      if (m_cd) begin
        stp = (m_f[0] == 1 && m_p[0] == 0);
        rv  = (m_f[1] == 1);
        er  = 0;
      end else begin
        er  = ach && bch;
        stp = m_4x ? (ach != bch) : (ach && !bch);
        rv  = ach ? (m_f[0] == m_f[1]) : (m_f[0] != m_f[1]);
      end
      rv = rv ^ m_dinv;
      ih = m_iinv ? (m_f[2] == 0 && m_p[2] == 1) : (m_f[2] == 1 && m_p[2] == 0);
      clrp = wr_en && wr_addr == 3'd1 && wr_data[0];
      arm  = wr_en && wr_addr == 3'd1 && wr_data[1];
      clrr = wr_en && wr_addr == 3'd1 && wr_data[3];
      pupd = 1;
      if (clrp || (ih && m_arm)) np = 0;
      else if (stp) np = rv ? ((m_pos == 0) ? m_max : m_pos - 1)
                            : ((m_pos == m_max) ? 0 : (m_pos + 1) % 65536);
      else begin np = m_pos; pupd = 0; end
      rupd = 1;
      if (clrr) nr = 0;
      else if (ih) nr = m_dir ? (m_rev + 4095) % 4096 : (m_rev + 1) % 4096;
      else begin nr = m_rev; rupd = 0; end
      for (int k = 0; k < 3; k++) m_hit[k] = pupd && (np == m_cmp[k]);
      m_rhit = rupd && (nr == m_rcmp);
      m_devt = stp && (rv != m_dir);
      if (stp) m_dir = rv;
      m_eevt = er; m_sevt = stp; m_ievt = ih;
      m_arm = arm || (m_arm && !ih);
      m_pos = np; m_rev = nr;
      for (int i = 0; i < 3; i++) begin
        m_p[i] = m_f[i];
        if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
        else if (m_cnt[i] >= m_len) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
        m_s2[i] = m_s1[i];
        m_s1[i] = in_v[i];
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_dinv = wr_data[0]; m_cd = wr_data[1]; m_4x = wr_data[2]; m_iinv = wr_data[3]; end
          3'd2: m_max = int'(wr_data);
          3'd3: m_len = int'(wr_data[7:0]);
          3'd4: m_cmp[0] = int'(wr_data);
          3'd5: m_cmp[1] = int'(wr_data);
          3'd6: m_cmp[2] = int'(wr_data);
          3'd7: m_rcmp = int'(wr_data[11:0]);
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle compare, event capture, watchdog ----------------
  bit seen_idx, seen_dchg, seen_err, seen_rhit;
  bit seen_hit[3];

  task automatic clear_seen();
    seen_idx = 0; seen_dchg = 0; seen_err = 0; seen_rhit = 0;
    for (int k = 0; k < 3; k++) seen_hit[k] = 0;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R4", "dir_o", int'(dir_o), int'(m_dir));
      check("R3", "pos_o", int'(pos_o), m_pos);
      check("R5", "rev_o", int'(rev_o), m_rev);
      for (int k = 0; k < 3; k++) check("R7", "pos_hit_o", int'(pos_hit_o[k]), int'(m_hit[k]));
      check("R8", "rev_hit_o", int'(rev_hit_o), int'(m_rhit));
      check("R5", "idx_evt_o", int'(idx_evt_o), int'(m_ievt));
      check("R4", "dir_evt_o", int'(dir_evt_o), int'(m_devt));
      check("R6", "err_evt_o", int'(err_evt_o), int'(m_eevt));
      check("R2", "step_evt_o", int'(step_evt_o), int'(m_sevt));
      if (idx_evt_o) seen_idx = 1;
      if (dir_evt_o) seen_dchg = 1;
      if (err_evt_o) seen_err = 1;
      if (rev_hit_o) seen_rhit = 1;
      for (int k = 0; k < 3; k++) if (pos_hit_o[k]) seen_hit[k] = 1;
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  int q = 0;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    tick(1);
    wr_en = 0;
    tick(1);
  endtask

  task automatic setq(int nq);
    q = nq;
    enc_a = (q == 1 || q == 2);
    enc_b = (q == 2 || q == 3);
    tick(HOLD);
  endtask

  task automatic fwd(int n);
    repeat (n) setq((q + 1) % 4);
  endtask

  task automatic rvs(int n);
    repeat (n) setq((q + 3) % 4);
  endtask

  task automatic idx_pulse();
    enc_idx = 1; tick(HOLD);
    enc_idx = 0; tick(HOLD);
  endtask

  task automatic a_pulse();
    enc_a = 1; tick(HOLD);
    enc_a = 0; tick(HOLD);
  endtask

  initial begin
    clear_seen();
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    check("R1", "pos after reset", int'(pos_o), 0);
    check("R1", "rev after reset", int'(rev_o), 0);
    check("R1", "dir after reset", int'(dir_o), 0);

    // 4X quadrature, maximum 9
    wreg(2, 9);
    wreg(0, 4);
    q = 1; enc_a = 1;
    tick(3);
    check("R11", "pos one cycle before due", int'(pos_o), 0);
    tick(1);
    check("R2", "first step lands on edge 4", int'(pos_o), 1);
    tick(HOLD - 4);
    fwd(11);
    check("R3", "pos after 12 forward steps wraps", int'(pos_o), 2);
    check("R4", "forward dir", int'(dir_o), 0);
    clear_seen();
    rvs(5);
    check("R3", "pos after 5 reverse steps wraps", int'(pos_o), 7);
    check("R4", "reverse dir", int'(dir_o), 1);
    check("R4", "direction change pulse", int'(seen_dchg), 1);

    // 2X quadrature: one full cycle gives two counts
    wreg(0, 0);
    fwd(4);
    check("R2", "2X full cycle counts two", int'(pos_o), 9);

    // phase error: both phases move together
    clear_seen();
    q = 1; enc_a = 1; enc_b = 0;
    tick(HOLD);
    check("R6", "error pulse", int'(seen_err), 1);
    check("R6", "pos held on error", int'(pos_o), 9);

    wreg(1, 1);
    check("R9", "pos cleared by command", int'(pos_o), 0);

    // index counting and revolution compare
    wreg(0, 4);
    wreg(7, 2);
    clear_seen();
    idx_pulse();
    check("R5", "index pulse seen", int'(seen_idx), 1);
    check("R5", "rev after one forward index", int'(rev_o), 1);
    idx_pulse();
    check("R8", "rev compare pulse", int'(seen_rhit), 1);

    // position compare channel 0
    wreg(4, 3);
    clear_seen();
    fwd(3);
    check("R7", "channel 0 hit", int'(seen_hit[0]), 1);
    check("R7", "channel 1 quiet", int'(seen_hit[1]), 0);

    // clear on index, then revolution clear
    wreg(1, 2);
    idx_pulse();
    check("R9", "pos cleared on armed index", int'(pos_o), 0);
    check("R5", "rev after third index", int'(rev_o), 3);
    wreg(1, 8);
    check("R9", "rev cleared by command", int'(rev_o), 0);

    // inverted index: only the falling edge counts
    wreg(0, 12);
    enc_idx = 1; tick(HOLD);
    check("R5", "rising edge ignored when inverted", int'(rev_o), 0);
    enc_idx = 0; tick(HOLD);
    check("R5", "falling edge counts when inverted", int'(rev_o), 1);

    // direction invert
    wreg(0, 5);
    fwd(2);
    check("R4", "inverted direction counts down", int'(pos_o), 8);
    check("R4", "inverted direction flag", int'(dir_o), 1);

    // clock/direction mode
    wreg(0, 2);
    enc_a = 0; enc_b = 0; tick(HOLD);
    check("R10", "no step on A fall or B change", int'(pos_o), 8);
    repeat (3) a_pulse();
    check("R10", "three forward clocks", int'(pos_o), 1);
    enc_b = 1; tick(HOLD);
    repeat (2) a_pulse();
    check("R10", "two reverse clocks", int'(pos_o), 9);
    check("R10", "B high is reverse", int'(dir_o), 1);

    // filter length 3: short glitch dropped, long level taken
    wreg(3, 3);
    wreg(0, 4);
    q = 3;
    enc_a = 1; tick(2);
    enc_a = 0; tick(HOLD);
    check("R11", "two-cycle glitch dropped", int'(pos_o), 9);
    q = 2; enc_a = 1;
    tick(6);
    check("R11", "pos one cycle before due", int'(pos_o), 9);
    tick(1);
    check("R11", "step after len+4 edges", int'(pos_o), 8);
    tick(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule